// File: doc/BRIEF.md
# Micro-Address Sequencer with Opcode Dispatch

This block produces the control-store address for a microprogrammed controller. A 4-bit micro-program counter holds the address of the microinstruction being executed. On each rising clock edge it loads a new value. A 2-bit next-address action field carried by the current microinstruction picks that value from one of three sources: zero (the instruction-fetch entry), an entry point looked up from the 6-bit instruction opcode, or the current address plus one.

The action field has four named values. FETCH (00) returns to address 0. DISPATCH (01) jumps through the opcode lookup table. STEP (10) advances to the next address and wraps from 15 to 0. RESERVED (11) behaves like FETCH.

The lookup table holds five entries:

| Instruction class | Opcode | Entry address |
|---|---|---|
| register-register | 000000 | 4 (0100) |
| branch-if-equal | 000100 | 3 (0011) |
| or-immediate | 001101 | 6 (0110) |
| load word | 100011 | 8 (1000) |
| store word | 101011 | 11 (1011) |

A DISPATCH on any other opcode sends the sequencer to address 0. It also raises a bad-opcode pulse for the cycle that follows.

The states of the block are its sixteen micro-addresses, with state 0 the fetch entry. Its transitions are the four actions listed above, plus synchronous reset.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `upc` becomes 0 and `bad_opcode` becomes 0, whatever `act_code` and `opcode` are.
- R2: Action code 00 (FETCH) at a rising edge loads `upc` with 0.
- R3: Action code 01 (DISPATCH) loads `upc` from the opcode table: 000000→4, 000100→3, 001101→6, 100011→8, 101011→11.
- R4: Action code 10 (STEP) loads `upc` with its previous value plus one, modulo 16, so 15 is followed by 0.
- R5: Action code 11 (RESERVED) loads `upc` with 0, the same as FETCH.
- R6: DISPATCH with an opcode missing from the table loads `upc` with 0 and sets `bad_opcode` to 1 for the following cycle only, unless the next edge is again such a dispatch.
- R7: `bad_opcode` is 0 after any edge that was not a DISPATCH of an unknown opcode. The opcode has no effect on `upc` or `bad_opcode` under FETCH, STEP or RESERVED.
- R8: `upc` and `bad_opcode` change only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| act_code | input | 2 | Next-address action: 00 fetch, 01 dispatch, 10 step, 11 reserved |
| opcode | input | 6 | Instruction opcode used by dispatch |
| upc | output | 4 | Current micro-address |
| bad_opcode | output | 1 | One-cycle pulse after a dispatch on an unknown opcode |

## Verification
On every cycle, the assertions check the edge-to-edge relation between the previous action and the new micro-address. That covers clear on FETCH and RESERVED, the increment with wrap on STEP, the reset value, and the rule that a bad-opcode pulse only follows a dispatch that landed on address 0. The actual entry addresses in the opcode table can only be shown by the bench, which dispatches each known opcode and several unknown ones. The bench scenarios also show the wrap after sixteen steps, reset taking effect in the middle of a walk, and the opcode being ignored by the non-dispatch actions.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W = 6;
    localparam int ENT_W = 4;

    typedef enum logic [1:0] {
        ACT_FETCH    = 2'b00,
        ACT_DISPATCH = 2'b01,
        ACT_STEP     = 2'b10,
        ACT_RSVD     = 2'b11
    } act_e;

    // opcode classes recognised by the dispatch table
    localparam logic [OPC_W-1:0] OPC_REGREG = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_BREQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_ORIMM  = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;

    // micro-entry points of each class
    localparam logic [ENT_W-1:0] ENT_FETCH  = 4'd0;
    localparam logic [ENT_W-1:0] ENT_REGREG = 4'd4;
    localparam logic [ENT_W-1:0] ENT_BREQ   = 4'd3;
    localparam logic [ENT_W-1:0] ENT_ORIMM  = 4'd6;
    localparam logic [ENT_W-1:0] ENT_LOAD   = 4'd8;
    localparam logic [ENT_W-1:0] ENT_STORE  = 4'd11;

endpackage

// File: rtl/useq_dispatch_rom.sv
module useq_dispatch_rom
    import useq_pkg::*;
#(
    parameter int UPC_W = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] entry,
    output logic             miss
);

    always_comb begin
        entry = UPC_W'(ENT_FETCH);
        miss  = 1'b0;
        unique case (opcode)
            OPC_REGREG: entry = UPC_W'(ENT_REGREG);
            OPC_BREQ:   entry = UPC_W'(ENT_BREQ);
            OPC_ORIMM:  entry = UPC_W'(ENT_ORIMM);
            OPC_LOAD:   entry = UPC_W'(ENT_LOAD);
            OPC_STORE:  entry = UPC_W'(ENT_STORE);
            default: begin
                entry = UPC_W'(ENT_FETCH);
                miss  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
    import useq_pkg::*;
#(
    parameter int UPC_W = 4
) (
    input  act_e             act,
    input  logic [UPC_W-1:0] upc_cur,
    input  logic [UPC_W-1:0] rom_entry,
    input  logic             rom_miss,
    output logic [UPC_W-1:0] upc_next,
    output logic             flag_next
);

    logic [UPC_W-1:0] upc_inc;

    assign upc_inc = upc_cur + UPC_W'(1);

    always_comb begin
        upc_next  = '0;
        flag_next = 1'b0;
        unique case (act)
            ACT_FETCH:    upc_next = '0;
            ACT_DISPATCH: begin
                upc_next  = rom_entry;
                flag_next = rom_miss;
            end
            ACT_STEP:     upc_next = upc_inc;
            ACT_RSVD:     upc_next = '0;
        endcase
    end

endmodule

// File: rtl/useq_upc_reg.sv
module useq_upc_reg #(
    parameter int UPC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [UPC_W-1:0] upc_next,
    input  logic             flag_next,
    output logic [UPC_W-1:0] upc_q,
    output logic             flag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            upc_q  <= upc_next;
            flag_q <= flag_next;
        end
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int UPC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       act_code,
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] upc,
    output logic             bad_opcode
);

    act_e             act;
    logic [UPC_W-1:0] rom_entry;
    logic             rom_miss;
    logic [UPC_W-1:0] upc_next;
    logic             flag_next;

    assign act = act_e'(act_code);

    useq_dispatch_rom #(.UPC_W(UPC_W)) u_rom (
        .opcode (opcode),
        .entry  (rom_entry),
        .miss   (rom_miss)
    );

    useq_next_sel #(.UPC_W(UPC_W)) u_sel (
        .act       (act),
        .upc_cur   (upc),
        .rom_entry (rom_entry),
        .rom_miss  (rom_miss),
        .upc_next  (upc_next),
        .flag_next (flag_next)
    );

    useq_upc_reg #(.UPC_W(UPC_W)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .upc_next  (upc_next),
        .flag_next (flag_next),
        .upc_q     (upc),
        .flag_q    (bad_opcode)
    );

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (upc == '0 && !bad_opcode)); // R1
    AST_FETCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(act_code) == 2'b00) |-> upc == '0); // R2
    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(act_code) == 2'b10) |-> upc == UPC_W'($past(upc) + UPC_W'(1))); // R4
    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(act_code) == 2'b11) |-> upc == '0); // R5
    AST_BAD_AT_FETCH: assert property (@(posedge clk) disable iff (rst)
        bad_opcode |-> upc == '0); // R6
    AST_BAD_ONLY_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        bad_opcode |-> (!$past(rst) && $past(act_code) == 2'b01)); // R7

endmodule

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/1ps
module useq_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] act_code = 2'b00;
    logic [5:0] opcode = 6'b0;
    logic [3:0] upc;
    logic       bad_opcode;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] model_upc = 4'd0;

    always #2.5 clk = ~clk;

    useq_sequencer u_useq_sequencer (
        .clk(clk), .rst(rst), .act_code(act_code), .opcode(opcode),
        .upc(upc), .bad_opcode(bad_opcode)
    );

    function automatic logic [4:0] table_of(input logic [5:0] op); // {miss, entry}
        case (op)
            6'b000000: return {1'b0, 4'd4};
            6'b000100: return {1'b0, 4'd3};
            6'b001101: return {1'b0, 4'd6};
            6'b100011: return {1'b0, 4'd8};
            6'b101011: return {1'b0, 4'd11};
            default:   return {1'b1, 4'd0};
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] exp_u, input logic exp_b);
        n_chk++;
        if (upc !== exp_u || bad_opcode !== exp_b) begin
            n_fail++;
            $display("FAIL %s: upc=%0d bad=%b expected upc=%0d bad=%b", req, upc, bad_opcode, exp_u, exp_b);
        end
    endtask

    // apply one action at a falling edge, let one rising edge pass, sample at next falling edge
    task automatic step(input logic [1:0] a, input logic [5:0] op, input string req);
        logic [4:0] t;
        logic       eb;
        t = table_of(op);
        eb = 1'b0;
        case (a)
            2'b00: model_upc = 4'd0;
            2'b01: begin model_upc = t[3:0]; eb = t[4]; end
            2'b10: model_upc = model_upc + 4'd1;
            default: model_upc = 4'd0;
        endcase
        act_code = a;
        opcode   = op;
        @(negedge clk);
        check(req, model_upc, eb);
    endtask

    task automatic t_reset;
        rst = 1'b1; act_code = 2'b10; opcode = 6'b111111;
        @(negedge clk); @(negedge clk);
        model_upc = 4'd0;
        check("R1 reset state", 4'd0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_dispatch_table;
        logic [5:0] ops [5] = '{6'b000000, 6'b000100, 6'b001101, 6'b100011, 6'b101011};
        for (int i = 0; i < 5; i++) begin
            step(2'b00, 6'b0, "R2 fetch before dispatch");
            step(2'b01, ops[i], "R3 dispatch entry");
        end
    endtask

    task automatic t_step_wrap;
        step(2'b00, 6'b0, "R2 fetch");
        for (int i = 0; i < 16; i++) step(2'b10, 6'b110011, "R4 step with wrap / R7 opcode ignored");
    endtask

    task automatic t_reserved;
        step(2'b01, 6'b100011, "R3 dispatch load");
        step(2'b11, 6'b000000, "R5 reserved returns to fetch");
        step(2'b10, 6'b0, "R4 step");
        step(2'b10, 6'b0, "R4 step");
        step(2'b11, 6'b111111, "R5 reserved with unknown opcode");
    endtask

    task automatic t_bad_opcode;
        step(2'b01, 6'b101011, "R3 dispatch store");
        step(2'b01, 6'b111111, "R6 unknown opcode dispatch");
        // held between edges (R8): sample again a quarter period later
        #1.25; check("R8 stable between edges", 4'd0, 1'b1);
        @(negedge clk);
        act_code = 2'b10;
        step(2'b10, 6'b111111, "R6 pulse lasts one cycle");
        step(2'b01, 6'b010101, "R6 second unknown dispatch");
        step(2'b01, 6'b000010, "R6 back-to-back unknown dispatch");
        step(2'b00, 6'b000010, "R7 fetch with unknown opcode clears flag");
    endtask

    task automatic t_reset_mid;
        step(2'b01, 6'b001101, "R3 dispatch or-immediate");
        step(2'b10, 6'b0, "R4 step");
        rst = 1'b1; act_code = 2'b01; opcode = 6'b111111;
        @(negedge clk);
        model_upc = 4'd0;
        check("R1 reset overrides dispatch", 4'd0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #100000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_dispatch_table();
        t_step_wrap();
        t_reserved();
        t_bad_opcode();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule